// File: doc/BRIEF.md
# Operand Effective-Address Generator

This block turns an addressing-mode code and the operand bytes of an instruction into a 16-bit effective address. It also uses the two index registers and the flag that relocates the direct page. A sequencer pulses `start` with the mode and operands on the inputs. The block returns the address with a one-cycle `done` pulse. The same port also carries jump targets: relative branches, short calls into the top page, and table calls through a descending vector table.

Three modes need a 16-bit pointer from memory: indexed-indirect, indirect-indexed and table call. For these the block runs a two-read sequence on a byte-wide read port, low byte first. All other modes resolve from the inputs alone. When the post-increment form of the X-indirect mode is used, the block flags with `done` that the caller must increment X.

Top module: `opaddr_gen`

## Requirements
- R1: After reset `done`, `x_inc` and `mem_req` are low and `ea` is 0x0000.
- R2: The direct page base is 0x0000 when `dp_sel`=0 and 0x0100 when `dp_sel`=1. Mode 0 gives base+`op_lo`. Mode 1 gives base+((`op_lo`+`idx_x`) mod 256). Mode 2 gives base+((`op_lo`+`idx_y`) mod 256).
- R3: Mode 3 gives {`op_hi`,`op_lo`}. Mode 4 adds `idx_x` to it modulo 65536, and mode 5 adds `idx_y` modulo 65536. Codes 13, 14 and 15 behave as mode 3.
- R4: Mode 6 gives direct page base+`idx_x`. Mode 7 gives the same address and raises `x_inc` together with `done`; in every other mode `x_inc` stays low.
- R5: Mode 10 gives (`pc` + sign-extended `op_lo`) modulo 65536.
- R6: Mode 11 gives 0xFF00+`op_lo`.
- R7: For modes other than 8, 9 and 12, `done` is high for exactly one cycle in the cycle after the start edge, and `mem_req` stays low.
- R8: Mode 8 reads a pointer at direct page offset (`op_lo`+`idx_x`) mod 256 (low byte) and at the next offset, which wraps within the page (high byte). `ea` is that pointer.
- R9: Mode 9 reads a pointer at direct page offsets `op_lo` and (`op_lo`+1) mod 256. `ea` is the pointer plus `idx_y`, modulo 65536.
- R10: Mode 12 takes n = `op_lo`[7:4] and reads the pointer at 0xFFDE-2n (low byte) and 0xFFDF-2n (high byte). `ea` is that pointer.
- R11: In modes 8, 9 and 12, `mem_req` is high for the two cycles after the start edge. The low-byte address comes first, then the high-byte address. `mem_data` carries each byte in the cycle after its request, and `done` rises three cycles after it would for a direct mode.
- R12: `start` is ignored from the start edge of a memory mode until its `done` cycle.
- R13: `ea` holds its value while no new request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation |
| mode | input | 4 | Addressing-mode code |
| op_lo | input | 8 | First operand byte (the opcode for table calls) |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | Index register X |
| idx_y | input | 8 | Index register Y |
| dp_sel | input | 1 | Direct page relocation flag |
| pc | input | 16 | Base for relative targets |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address or target |
| x_inc | output | 1 | Caller must increment X |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| mem_data | input | 8 | Read data, one cycle after the request |

## Verification
The bound checker watches four things on every cycle. Every pointer fetch has the shape of two requests, one idle cycle and then `done`. The second read address stays in the same page as the first, one byte above it, so the wrap within the direct page holds. `x_inc` never appears without `done`, and `done` never overlaps a request. The address arithmetic itself is only shown by the bench's scenarios, which compare every cycle against a model. Those scenarios cover the page relocation, index wrap in both the page and the full range, signed relative offsets, the last and first vectors of the table, and starts sent while a fetch is running.

// File: rtl/opaddr_gen.sv
module opaddr_gen #(
  parameter logic [15:0] SHORT_BASE = 16'hFF00,
  parameter logic [15:0] VEC_BASE   = 16'hFFDE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic [7:0]  op_lo,
  input  logic [7:0]  op_hi,
  input  logic [7:0]  idx_x,
  input  logic [7:0]  idx_y,
  input  logic        dp_sel,
  input  logic [15:0] pc,
  output logic        done,
  output logic [15:0] ea,
  output logic        x_inc,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_data
);
  localparam logic [3:0] M_DP = 4'd0, M_DPX = 4'd1, M_DPY = 4'd2, M_ABS = 4'd3,
                         M_ABSX = 4'd4, M_ABSY = 4'd5, M_IX = 4'd6, M_IXP = 4'd7,
                         M_IDXI = 4'd8, M_INDI = 4'd9, M_REL = 4'd10,
                         M_SCALL = 4'd11, M_TCALL = 4'd12;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_FIN} state_t;
  state_t st;

  logic [15:0] a_lo, a_hi, direct_ea, p_lo, p_hi, abs_w, vec;
  logic [7:0]  add_y, ptr_lo, off_x, off_x1, off_y, lo1;
  logic        need_mem;

  assign abs_w  = {op_hi, op_lo};
  assign off_x  = op_lo + idx_x;
  assign off_x1 = off_x + 8'd1;
  assign off_y  = op_lo + idx_y;
  assign lo1    = op_lo + 8'd1;
  assign vec    = VEC_BASE - {11'd0, op_lo[7:4], 1'b0};
  assign need_mem = (mode == M_IDXI) || (mode == M_INDI) || (mode == M_TCALL);

  always_comb begin
    case (mode)
      M_DP:    direct_ea = {7'd0, dp_sel, op_lo};
      M_DPX:   direct_ea = {7'd0, dp_sel, off_x};
      M_DPY:   direct_ea = {7'd0, dp_sel, off_y};
      M_ABSX:  direct_ea = abs_w + {8'd0, idx_x};
      M_ABSY:  direct_ea = abs_w + {8'd0, idx_y};
      M_IX,
      M_IXP:   direct_ea = {7'd0, dp_sel, idx_x};
      M_REL:   direct_ea = pc + {{8{op_lo[7]}}, op_lo};
      M_SCALL: direct_ea = SHORT_BASE + {8'd0, op_lo};
      default: direct_ea = abs_w;
    endcase
  end

  always_comb begin
    case (mode)
      M_IDXI: begin
        p_lo = {7'd0, dp_sel, off_x};
        p_hi = {7'd0, dp_sel, off_x1};
      end
      M_INDI: begin
        p_lo = {7'd0, dp_sel, op_lo};
        p_hi = {7'd0, dp_sel, lo1};
      end
      default: begin
        p_lo = vec;
        p_hi = vec + 16'd1;
      end
    endcase
  end

  assign mem_req  = (st == S_LO) || (st == S_HI);
  assign mem_addr = (st == S_HI) ? a_hi : a_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      x_inc  <= 1'b0;
      ea     <= 16'd0;
      a_lo   <= 16'd0;
      a_hi   <= 16'd0;
      add_y  <= 8'd0;
      ptr_lo <= 8'd0;
    end else begin
      done  <= 1'b0;
      x_inc <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (need_mem) begin
            a_lo  <= p_lo;
            a_hi  <= p_hi;
            add_y <= (mode == M_INDI) ? idx_y : 8'd0;
            st    <= S_LO;
          end else begin
            ea    <= direct_ea;
            done  <= 1'b1;
            x_inc <= (mode == M_IXP);
          end
        end
        S_LO: st <= S_HI;
        S_HI: begin
          ptr_lo <= mem_data;
          st     <= S_FIN;
        end
        default: begin
          ea   <= {mem_data, ptr_lo} + {8'd0, add_y};
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        x_inc,
  input logic        mem_req,
  input logic [15:0] mem_addr
);
  p_fetch_shape_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |=> mem_req ##1 !mem_req ##1 done);

  p_hi_byte_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |=> (mem_addr[15:8] == $past(mem_addr[15:8])) &&
                       (mem_addr[7:0] == $past(mem_addr[7:0]) + 8'd1));

  p_xinc_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    x_inc |-> done);

  p_done_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
endmodule

bind opaddr_gen opaddr_gen_chk u_chk (.*);

// File: tb/opaddr_gen_test.sv
module opaddr_gen_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dp_sel = 1'b0;
  logic [3:0] mode = 4'd0;
  logic [7:0] op_lo = 8'd0, op_hi = 8'd0, idx_x = 8'd0, idx_y = 8'd0, mem_data = 8'd0;
  logic [15:0] pc = 16'd0;
  logic done, x_inc, mem_req;
  logic [15:0] ea, mem_addr;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  opaddr_gen uut (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_lo(op_lo),
    .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y), .dp_sel(dp_sel), .pc(pc), .done(done),
    .ea(ea), .x_inc(x_inc), .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data));

  function automatic logic [7:0] fbyte(input int a);
    return 8'((a & 255) ^ (((a >> 8) * 7) & 255) ^ 8'hA5);
  endfunction

  always @(posedge clk) mem_data <= mem_req ? fbyte(int'(mem_addr)) : 8'h00;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input int m, input int lo, input int hi, input int x, input int y,
                        input int p, input int pcv, input string tag);
    int page, e, lat, ra0, ra1, sl;
    bit xi;
    page = p ? 256 : 0;
    lat = 1; ra0 = 0; ra1 = 0; xi = (m == 7);
    sl = (lo >= 128) ? lo - 256 : lo;
    case (m)
      0: e = page + lo;
      1: e = page + (lo + x) % 256;
      2: e = page + (lo + y) % 256;
      4: e = (hi * 256 + lo + x) % 65536;
      5: e = (hi * 256 + lo + y) % 65536;
      6, 7: e = page + x;
      10: e = (pcv + 65536 + sl) % 65536;
      11: e = 65280 + lo;
      8: begin ra0 = page + (lo + x) % 256; ra1 = page + (lo + x + 1) % 256; lat = 4; end
      9: begin ra0 = page + lo; ra1 = page + (lo + 1) % 256; lat = 4; end
      12: begin ra0 = 65502 - 2 * (lo / 16); ra1 = ra0 + 1; lat = 4; end
      default: e = hi * 256 + lo;
    endcase
    if (lat == 4) begin
      e = int'(fbyte(ra1)) * 256 + int'(fbyte(ra0));
      if (m == 9) e = (e + y) % 65536;
    end
    @(negedge clk);
    mode = 4'(m); op_lo = 8'(lo); op_hi = 8'(hi); idx_x = 8'(x); idx_y = 8'(y);
    dp_sel = 1'(p); pc = 16'(pcv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= lat; k++) begin
      if (k > 1) @(negedge clk);
      chk(done == (k == lat), {tag, " R7/R11 done timing"}, int'(done), int'(k == lat));
      if (lat == 1) chk(!mem_req, {tag, " R7 no request"}, int'(mem_req), 0);
      else if (k <= 2) begin
        chk(mem_req && int'(mem_addr) == ((k == 1) ? ra0 : ra1), {tag, " R11 read address"},
            int'(mem_addr), (k == 1) ? ra0 : ra1);
      end else chk(!mem_req, {tag, " R11 request ends"}, int'(mem_req), 0);
    end
    chk(int'(ea) == e, {tag, " ea"}, int'(ea), e);
    chk(x_inc == xi, {tag, " R4 x_inc"}, int'(x_inc), int'(xi));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!done && !x_inc && !mem_req && ea == 16'd0, "R1 reset", int'(ea), 0);

    run_op(0, 8'h34, 0, 0, 0, 0, 0, "R2 dp page0");
    run_op(0, 8'h34, 0, 0, 0, 1, 0, "R2 dp page1");
    run_op(1, 8'hF0, 0, 8'h20, 0, 1, 0, "R2 dp+x wrap");
    run_op(2, 8'hFF, 0, 0, 8'h01, 0, 0, "R2 dp+y wrap");
    run_op(3, 8'hCD, 8'hAB, 0, 0, 1, 0, "R3 abs");
    run_op(4, 8'hF0, 8'hFF, 8'h20, 0, 0, 0, "R3 abs+x wrap");
    run_op(5, 8'hF0, 8'h12, 0, 8'h30, 0, 0, "R3 abs+y carry");
    run_op(14, 8'h11, 8'h22, 8'h05, 8'h06, 1, 0, "R3 reserved code");
    run_op(6, 8'h99, 0, 8'h7E, 0, 1, 0, "R4 (x)");
    run_op(7, 8'h99, 0, 8'h7E, 0, 0, 0, "R4 (x)+");
    run_op(10, 8'h10, 0, 0, 0, 0, 16'h1234, "R5 rel forward");
    run_op(10, 8'hFE, 0, 0, 0, 0, 16'h0001, "R5 rel backward wrap");
    run_op(11, 8'h42, 0, 0, 0, 1, 0, "R6 short call");
    run_op(8, 8'h10, 0, 8'h05, 0, 1, 0, "R8 indexed indirect");
    run_op(8, 8'hFE, 0, 8'h01, 0, 0, 0, "R8 pointer wraps in page");
    run_op(9, 8'h40, 0, 0, 8'h03, 0, 0, "R9 indirect indexed");
    run_op(9, 8'hFF, 0, 0, 8'hFF, 1, 0, "R9 page wrap and y add");
    run_op(12, 8'h01, 0, 0, 0, 0, 0, "R10 table n=0");
    run_op(12, 8'hF1, 0, 0, 0, 1, 0, "R10 table n=15");

    // R12: start held high through a running fetch is ignored
    begin
      int e;
      e = (int'(fbyte(16'h0041)) * 256 + int'(fbyte(16'h0040)) + 3) % 65536;
      @(negedge clk);
      mode = 4'd9; op_lo = 8'h40; idx_y = 8'h03; dp_sel = 1'b0; start = 1'b1;
      @(negedge clk);
      mode = 4'd11; op_lo = 8'h77;
      chk(!done, "R12 busy no done 1", int'(done), 0);
      @(negedge clk);
      chk(!done, "R12 busy no done 2", int'(done), 0);
      @(negedge clk);
      chk(!done, "R12 busy no done 3", int'(done), 0);
      @(negedge clk);
      start = 1'b0;
      chk(done && int'(ea) == e, "R12 first result kept", int'(ea), e);
      @(negedge clk);
      chk(!done, "R12 no extra done", int'(done), 0);
      // R13 hold
      repeat (3) @(negedge clk);
      chk(!done && int'(ea) == e, "R13 ea held", int'(ea), e);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule